// File: doc/BRIEF.md
# Windowed Address Partition Translator

This block maps a flat host-side virtual address space onto device physical addresses through four programmable windows. Windows 0, 2 and 3 map memory and window 1 maps registers. The windows sit back to back in virtual space. Window 0 begins at virtual address 0, and each later window begins where the previous one ends. A window's virtual base is therefore the sum of the sizes of the windows before it. It is never programmed on its own.

Seven 32-bit configuration values are loaded through a simple write port. Each window has a physical start value. Windows 0 to 2 also have a size value. Window 3 has no size: it runs from the end of window 2 up to a parameterised top of the virtual space.

A lookup request carries a virtual address and a valid strobe. One clock later the block returns three results: the physical address, the index of the window that was hit, and a miss flag.

Top module: `addr_window_xlate`

## Requirements
- R1: After reset all four start values and all three size values are 0 and `rsp_valid` is 0. An address below `VIRT_LIMIT` then resolves to window 3 with a physical address equal to the virtual address.
- R2: A write with `cfg_we` high stores `cfg_data` into the slot chosen by `cfg_idx`: 0 = start0, 1 = size0, 2 = start1, 3 = size1, 4 = start2, 5 = size2, 6 = start3. A write with `cfg_idx` = 7 changes nothing.
- R3: A virtual address v with v < size0 hits window 0 (`rsp_win` = 0) and returns start0 + v.
- R4: An address with size0 <= v < size0+size1 hits window 1 and returns start1 + (v - size0).
- R5: An address with size0+size1 <= v < size0+size1+size2 hits window 2 and returns start2 + (v - size0 - size1).
- R6: An address with size0+size1+size2 <= v < `VIRT_LIMIT` hits window 3 and returns start3 + (v - size0 - size1 - size2).
- R7: A window whose size is 0 never matches any address. Addresses at its base fall to the next window.
- R8: An address at or above `VIRT_LIMIT` asserts `rsp_miss`, drives `rsp_paddr` to 0 and drives `rsp_win` to 0.
- R9: `rsp_valid` is high exactly one clock after a cycle with `req_valid` high. The results belong to that request.
- R10: If a configuration write and a request occur in the same cycle, the request uses the configuration from before the write.
- R11: The physical address sum wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Configuration slot selector |
| cfg_data | input | 32 | Configuration write value |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Result valid, one clock after request |
| rsp_paddr | output | 32 | Translated physical address (0 on miss) |
| rsp_win | output | 2 | Index of the window that was hit |
| rsp_miss | output | 1 | Address lies in no window |

## Verification
The bench probes the first and last address of every window. A design that computes a base wrongly by one, or uses the wrong comparison at a boundary, would send those addresses to a neighbouring window or offset them by a single byte.

Two size registers are then zeroed. A design that still matched an empty window would report it at the shared base instead of passing the address on. Slot 7 is written to catch a decoder that aliases onto a real slot.

Other checks cover physical addresses that wrap past the 32-bit boundary and a configuration write that lands in the same cycle as a request. A design that forwarded the new value too early would return the updated start for the earlier request.

// File: rtl/addr_window_xlate.sv
module addr_window_xlate #(
  parameter int              AW         = 32,
  parameter logic [AW-1:0]   VIRT_LIMIT = 32'h0080_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_idx,
  input  logic [AW-1:0] cfg_data,
  input  logic          req_valid,
  input  logic [AW-1:0] req_vaddr,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_paddr,
  output logic [1:0]    rsp_win,
  output logic          rsp_miss
);
  localparam int SW   = AW + 2;
  localparam int NWIN = 4;

  logic [AW-1:0] start_q [NWIN];
  logic [AW-1:0] size_q  [NWIN-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++)   start_q[i] <= '0;
      for (int i = 0; i < NWIN-1; i++) size_q[i]  <= '0;
    end else if (cfg_we && cfg_idx != 3'd7) begin
      if (cfg_idx[0]) size_q[cfg_idx[2:1]]  <= cfg_data;
      else            start_q[cfg_idx[2:1]] <= cfg_data;
    end
  end

  logic [SW-1:0] base [NWIN];
  logic [SW-1:0] v;
  logic [NWIN-1:0] hit;

  assign v       = {2'b00, req_vaddr};
  assign base[0] = '0;

  genvar g;
  generate
    for (g = 0; g < NWIN-1; g++) begin : g_win
      assign base[g+1] = base[g] + {2'b00, size_q[g]};
      assign hit[g]    = (size_q[g] != '0) && (v >= base[g]) && (v < base[g+1]);
    end
  endgenerate

  logic in_space;
  assign in_space  = req_vaddr < VIRT_LIMIT;
  assign hit[NWIN-1] = v >= base[NWIN-1];

  logic [1:0]    win_d;
  logic          miss_d;
  logic [AW-1:0] paddr_d;

  always_comb begin
    win_d   = 2'd0;
    miss_d  = 1'b1;
    paddr_d = '0;
    if (in_space) begin
      for (int i = NWIN-1; i >= 0; i--) begin
        if (hit[i]) begin
          win_d   = 2'(i);
          miss_d  = 1'b0;
          paddr_d = start_q[i] + AW'(v - base[i]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_win   <= '0;
      rsp_miss  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_paddr <= paddr_d;
        rsp_win   <= win_d;
        rsp_miss  <= miss_d;
      end
    end
  end

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_paddr == '0 && rsp_win == 2'd0));
  assert_beyond_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_vaddr >= VIRT_LIMIT) |=> rsp_miss);
  assert_empty_win0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && size_q[0] == '0) |=> (rsp_miss || rsp_win != 2'd0));
  assert_empty_win1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && size_q[1] == '0) |=> (rsp_miss || rsp_win != 2'd1));
  assert_win0_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_miss && rsp_win == 2'd0) |->
      rsp_paddr == $past(start_q[0]) + $past(req_vaddr));
endmodule

// File: tb/tb_addr_window_xlate.sv
module tb_addr_window_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_win;
  logic        rsp_miss;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  addr_window_xlate dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_win(rsp_win),
    .rsp_miss(rsp_miss)
  );

  // {vaddr, paddr, win, miss}
  localparam int NV = 10;
  localparam logic [66:0] VEC [NV] = '{
    {32'h0000_0000, 32'h1000_0000, 2'd0, 1'b0},
    {32'h0000_0FFF, 32'h1000_0FFF, 2'd0, 1'b0},
    {32'h0000_1000, 32'h2000_0000, 2'd1, 1'b0},
    {32'h0000_17FF, 32'h2000_07FF, 2'd1, 1'b0},
    {32'h0000_1800, 32'h3000_0000, 2'd2, 1'b0},
    {32'h0000_18FF, 32'h3000_00FF, 2'd2, 1'b0},
    {32'h0000_1900, 32'h4000_0000, 2'd3, 1'b0},
    {32'h007F_FFFF, 32'h407F_E6FF, 2'd3, 1'b0},
    {32'h0080_0000, 32'h0000_0000, 2'd0, 1'b1},
    {32'hFFFF_FFFF, 32'h0000_0000, 2'd0, 1'b1}
  };

  task automatic cfg_write(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_data = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic check(input string req, input logic [31:0] ep,
                       input logic [1:0] ew, input logic em);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_paddr !== ep || rsp_win !== ew || rsp_miss !== em) begin
      errors++;
      $display("FAIL %s: got v=%0b pa=%h w=%0d m=%0b, expected v=1 pa=%h w=%0d m=%0b",
               req, rsp_valid, rsp_paddr, rsp_win, rsp_miss, ep, ew, em);
    end
  endtask

  task automatic lookup(input string req, input logic [31:0] va,
                        input logic [31:0] ep, input logic [1:0] ew, input logic em);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, ep, ew, em);
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: got rsp_valid=%0b, expected 0", rsp_valid);
    end
    rst_n = 1'b1;
    lookup("R1", 32'h0000_1234, 32'h0000_1234, 2'd3, 1'b0);

    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9: got rsp_valid=%0b on idle cycle, expected 0", rsp_valid);
    end

    cfg_write(3'd0, 32'h1000_0000);
    cfg_write(3'd1, 32'h0000_1000);
    cfg_write(3'd2, 32'h2000_0000);
    cfg_write(3'd3, 32'h0000_0800);
    cfg_write(3'd4, 32'h3000_0000);
    cfg_write(3'd5, 32'h0000_0100);
    cfg_write(3'd6, 32'h4000_0000);

    for (int i = 0; i < NV; i++) begin
      string tag;
      logic [1:0] w;
      w = VEC[i][2:1];
      tag = VEC[i][0] ? "R8" : (w == 2'd0 ? "R3" : w == 2'd1 ? "R4" : w == 2'd2 ? "R5" : "R6");
      lookup(tag, VEC[i][66:35], VEC[i][34:3], w, VEC[i][0]);
    end

    // slot 7 must not alias any real slot (R2)
    cfg_write(3'd7, 32'hFFFF_FFFF);
    lookup("R2", 32'h0000_0000, 32'h1000_0000, 2'd0, 1'b0);
    lookup("R2", 32'h0000_1900, 32'h4000_0000, 2'd3, 1'b0);

    // zero-size windows are skipped (R7)
    cfg_write(3'd3, 32'h0);
    lookup("R7", 32'h0000_1000, 32'h3000_0000, 2'd2, 1'b0);
    lookup("R7", 32'h0000_1100, 32'h4000_0000, 2'd3, 1'b0);
    cfg_write(3'd1, 32'h0);
    lookup("R7", 32'h0000_0000, 32'h3000_0000, 2'd2, 1'b0);

    // wrap of the physical sum (R11)
    cfg_write(3'd6, 32'hFFFF_FFF0);
    lookup("R11", 32'h0000_0120, 32'h0000_0010, 2'd3, 1'b0);

    // write and request in the same cycle (R10)
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h0000_0120;
    cfg_we = 1'b1; cfg_idx = 3'd6; cfg_data = 32'h5000_0000;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    check("R10", 32'h0000_0010, 2'd3, 1'b0);
    lookup("R10", 32'h0000_0120, 32'h5000_0020, 2'd3, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule